// File: doc/BRIEF.md
# Programming Status Readback Logic

This block sits between the read port of a byte-wide nonvolatile array and the data output pins. While no internal programming cycle is running it hands the array word through untouched. While a programming cycle runs, a read returns a status word instead of array data, so a host can find out when the write has finished without a dedicated status pin.

The status word carries two indications on the normal data bus. The top bit shows the complement of the top bit of the last byte loaded. Once programming ends, the real stored value appears and the two agree. The next bit down flips on each read access. The first access after programming starts returns a 1, and the flipping stops when the cycle ends. A read access is counted once, on the cycle in which the combined chip-enable and output-enable request becomes active, however long that request is held. The remaining status bits read as zero. Generating the busy flag and performing the programming lie outside this block. For toggle polling, the host is expected to keep the read address fixed.

Top module: `prog_status_readback`

## Requirements
- R1: While `busy` is 0, `dout` equals `array_data` in the same cycle, for every data value.
- R2: While `busy` is 1, `dout` bit 7 equals the complement of `wr_ref_msb`.
- R3: While `busy` is 1, `dout` bits 5 down to 0 are all zero.
- R4: After `busy` goes from 0 to 1, `dout` bit 6 is 0 until the first access edge. The first access edge (a cycle where `rd_act` is 1 after being 0 the cycle before) sets `dout` bit 6 to 1 from the following cycle.
- R5: Each further access edge while `busy` stays 1 inverts `dout` bit 6 from the following cycle.
- R6: Holding `rd_act` at 1 for several cycles counts as a single access, so `dout` bit 6 does not change while the request stays active.
- R7: When `busy` returns to 0, toggling stops and `dout` follows `array_data`. A later busy period starts again from R4.
- R8: While `rst_n` is 0, the access history and toggle state are cleared. An access whose request is already at 1 when reset is released counts as an edge in the first cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| busy | input | 1 | Internal programming cycle in progress |
| wr_ref_msb | input | 1 | Top bit of the last byte loaded |
| rd_act | input | 1 | Combined chip-enable and output-enable read request, active high |
| array_data | input | 8 | Word from the array read port |
| dout | output | 8 | Word returned to the data pins |

## Verification
The pass-through path is swept over all 256 array words with busy low, both with and without read requests. This separates a true bypass from a path that leaks status bits. The status path is swept over both reference-bit values with non-zero array words behind it. This shows that bit 7 is inverted and that bits 5..0 are forced to zero rather than taken from the array. Sequences of short read pulses are compared with long held requests, and the expected bit 6 is computed from the parity of the edge count. This tells per-edge counting apart from per-cycle counting. Repeated busy periods, and reset released while a request is already held, confirm that the toggle restarts at 1.

// File: rtl/psr_pkg.sv
package psr_pkg;
  typedef enum logic {SRC_ARRAY = 1'b0, SRC_STATUS = 1'b1} src_sel_e;

  // Parity of access count -> value of the toggle bit in the status word.
  function automatic logic toggle_from_parity(input logic odd_count);
    return odd_count;
  endfunction
endpackage

// File: rtl/psr_access_edge.sv
module psr_access_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic req,
  output logic start
);
  logic req_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) req_q <= 1'b0;
    else        req_q <= req;
  end

  assign start = req & ~req_q;
endmodule

// File: rtl/psr_toggle_track.sv
module psr_toggle_track (
  input  logic clk,
  input  logic rst_n,
  input  logic busy,
  input  logic acc_start,
  output logic tgl
);
  import psr_pkg::*;
  logic odd_q;
  logic odd_d;

  always_comb begin
    if (!busy) odd_d = 1'b0;
    else       odd_d = odd_q ^ acc_start;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) odd_q <= 1'b0;
    else        odd_q <= odd_d;
  end

  assign tgl = toggle_from_parity(odd_q);
endmodule

// File: rtl/psr_out_mux.sv
module psr_out_mux #(
  parameter int DATA_W   = 8,
  parameter int POLL_POS = 7,
  parameter int TGL_POS  = 6
) (
  input  psr_pkg::src_sel_e sel,
  input  logic              ref_msb,
  input  logic              tgl,
  input  logic [DATA_W-1:0] array_data,
  output logic [DATA_W-1:0] dout
);
  import psr_pkg::*;
  logic [DATA_W-1:0] status_word;

  for (genvar i = 0; i < DATA_W; i++) begin : g_bit
    if (i == POLL_POS) begin : g_poll
      assign status_word[i] = ~ref_msb;
    end else if (i == TGL_POS) begin : g_tgl
      assign status_word[i] = tgl;
    end else begin : g_zero
      assign status_word[i] = 1'b0;
    end
  end

  assign dout = (sel == SRC_STATUS) ? status_word : array_data;
endmodule

// File: rtl/prog_status_readback.sv
module prog_status_readback #(
  parameter int DATA_W   = 8,
  parameter int POLL_POS = DATA_W - 1,
  parameter int TGL_POS  = DATA_W - 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              busy,
  input  logic              wr_ref_msb,
  input  logic              rd_act,
  input  logic [DATA_W-1:0] array_data,
  output logic [DATA_W-1:0] dout
);
  import psr_pkg::*;

  logic      rd_start;
  logic      tgl_bit;
  src_sel_e  src_sel;

  psr_access_edge u_edge (
    .clk   (clk),
    .rst_n (rst_n),
    .req   (rd_act),
    .start (rd_start)
  );

  psr_toggle_track u_tgl (
    .clk       (clk),
    .rst_n     (rst_n),
    .busy      (busy),
    .acc_start (rd_start),
    .tgl       (tgl_bit)
  );

  assign src_sel = busy ? SRC_STATUS : SRC_ARRAY;

  psr_out_mux #(
    .DATA_W   (DATA_W),
    .POLL_POS (POLL_POS),
    .TGL_POS  (TGL_POS)
  ) u_mux (
    .sel        (src_sel),
    .ref_msb    (wr_ref_msb),
    .tgl        (tgl_bit),
    .array_data (array_data),
    .dout       (dout)
  );
endmodule

// File: rtl/prog_status_readback_chk.sv
module prog_status_readback_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       busy,
  input logic       wr_ref_msb,
  input logic       rd_start,
  input logic [7:0] array_data,
  input logic [7:0] dout
);
  // R1
  pass_through_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> dout == array_data);
  // R2
  poll_invert_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> dout[7] != wr_ref_msb);
  // R3
  low_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> dout[5:0] == 6'd0);
  // R4
  fresh_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> dout[6] == 1'b0);
  // R5
  flip_on_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && rd_start) |=> (busy |-> dout[6] != $past(dout[6])));
  // R6
  hold_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !rd_start) |=> (busy |-> $stable(dout[6])));
endmodule

bind prog_status_readback prog_status_readback_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .busy       (busy),
  .wr_ref_msb (wr_ref_msb),
  .rd_start   (rd_start),
  .array_data (array_data),
  .dout       (dout)
);

// File: tb/prog_status_readback_test.sv
module prog_status_readback_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       busy = 1'b0;
  logic       wr_ref_msb = 1'b0;
  logic       rd_act = 1'b0;
  logic [7:0] array_data = 8'h00;
  logic [7:0] dout;
  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  prog_status_readback uut (
    .clk(clk), .rst_n(rst_n), .busy(busy), .wr_ref_msb(wr_ref_msb),
    .rd_act(rd_act), .array_data(array_data), .dout(dout)
  );

  function automatic logic [7:0] expect_status(input logic ref_b, input int edges);
    return 8'((ref_b ? 0 : 128) + ((edges % 2) * 64));
  endfunction

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); @(negedge clk);
  endtask

  // one short access: request high for one cycle, then low for one
  task automatic pulse_read();
    rd_act = 1'b1; step();
    rd_act = 1'b0; step();
  endtask

  initial begin
    #20000000;
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    int edges;
    step(); step();
    // R8 reset state: passthrough and clear toggle
    check("R8_reset_pass", dout, array_data);
    rst_n = 1'b1; step();

    // R1 sweep all array words, with and without read requests
    for (int v = 0; v < 256; v++) begin
      array_data = 8'(v);
      rd_act = v[0];
      #1;
      check("R1_pass", dout, 8'(v));
      step();
      check("R1_pass_clk", dout, 8'(v));
    end
    rd_act = 1'b0; step();

    // R2/R3 sweep reference bit against all array words
    busy = 1'b1;
    for (int v = 0; v < 512; v++) begin
      array_data = 8'(v);
      wr_ref_msb = v[8];
      #1;
      check("R2_R3_status", dout, expect_status(v[8], 0));
    end
    // R4 bit 6 is 0 before any access edge
    check("R4_pre", dout, expect_status(wr_ref_msb, 0));

    // R4/R5 short pulses
    edges = 0;
    for (int k = 0; k < 9; k++) begin
      rd_act = 1'b1; step(); edges++;
      check(k == 0 ? "R4_first" : "R5_flip", dout, expect_status(wr_ref_msb, edges));
      rd_act = 1'b0; step();
      check("R5_between", dout, expect_status(wr_ref_msb, edges));
    end

    // R6 held request counts once
    rd_act = 1'b1; step(); edges++;
    for (int k = 0; k < 6; k++) begin
      step();
      check("R6_held", dout, expect_status(wr_ref_msb, edges));
    end
    rd_act = 1'b0; step();
    check("R6_release", dout, expect_status(wr_ref_msb, edges));

    // R7 busy drops: passthrough, no toggling on reads
    busy = 1'b0; array_data = 8'hC3; #1;
    check("R7_end_pass", dout, 8'hC3);
    for (int k = 0; k < 3; k++) begin
      pulse_read();
      check("R7_no_toggle", dout, 8'hC3);
    end
    // R7 new busy period restarts
    busy = 1'b1; wr_ref_msb = 1'b1; step();
    check("R7_restart_pre", dout, expect_status(1'b1, 0));
    rd_act = 1'b1; step();
    check("R7_restart_first", dout, expect_status(1'b1, 1));
    rd_act = 1'b0; step();
    // busy rising while a request is already held: no edge yet
    busy = 1'b0; rd_act = 1'b1; step();
    busy = 1'b1; step();
    check("R6_busy_under_held", dout, expect_status(1'b1, 0));
    rd_act = 1'b0; step();

    // R8 reset with request held: first cycle after release is an edge
    pulse_read();
    rst_n = 1'b0; rd_act = 1'b1; step();
    check("R8_in_reset", dout, expect_status(1'b1, 0));
    rst_n = 1'b1; step();
    check("R8_edge_after_reset", dout, expect_status(1'b1, 1));
    step();
    check("R8_held_after_reset", dout, expect_status(1'b1, 1));
    rd_act = 1'b0; busy = 1'b0; step();

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule